// File: doc/BRIEF.md
# Bit-Field Read-Modify-Write Engine

This block updates a single bit field inside one 32-bit register that sits on a simple memory-mapped bus. A requester hands over a base address, a packed field descriptor and a new value. The engine works out the target address and the field geometry from the descriptor, fetches the current word, replaces only the addressed field and stores the word back. Every other bit of the register keeps the value it was read with.

The descriptor is one 32-bit word. Bits 7:0 give the field's lowest bit position, bits 15:8 give its width in bits, and bits 31:16 give an unsigned byte offset added to the base address. A descriptor that does not describe a field inside the word is refused with an error pulse and causes no bus traffic.

Requests use a valid/ready handshake. `req_valid` may be raised at any time, and the requester holds it, with the base, descriptor and value steady, until it samples `req_ready` high at a clock edge. `req_ready` is high only while the engine is idle, so at most one operation is in flight. On the bus side, each read and each write holds its strobe, address and (for a write) data steady until the slave returns `bus_ready`.

Top module: `regfield_rmw`

## Requirements
- R1: The bus address of both accesses equals `req_base` plus descriptor bits 31:16, zero-extended and taken modulo 2^ADDR_W.
- R2: The value is cut to the field width (descriptor bits 15:8) before insertion, so value bits at positions at or above the width never reach the register.
- R3: In the word written back, bits from offset (descriptor bits 7:0) to offset+width-1 carry the truncated value, and every other bit equals the word that was read.
- R4: Each accepted legal request produces exactly one read and then exactly one write, both to the same address.
- R5: `bus_rd` or `bus_wr` stays high with an unchanged address (and unchanged `bus_wdata` for a write) until the cycle in which `bus_ready` is high. Each wait cycle delays completion by one cycle.
- R6: `req_ready` is high only when the engine is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle until the operation ends.
- R7: `done` is high for exactly one cycle, the cycle after the write is accepted. With no wait states, that is the third cycle after acceptance.
- R8: A descriptor with width 0, width above 32, or offset+width above 32 raises `err` for one cycle, in the cycle after acceptance. It issues no read or write and does not raise `done`.
- R9: Width 32 with offset 0 replaces the whole word with the value.
- R10: After reset, `req_ready` is high and `bus_rd`, `bus_wr`, `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_base | input | ADDR_W | Base byte address |
| req_desc | input | 32 | Packed field descriptor (offset 31:16, width 15:8, bit position 7:0) |
| req_value | input | DATA_W | New field value, right-aligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the write completes |
| err | output | 1 | One-cycle pulse for a refused descriptor |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid while bus_ready is high during a read |
| bus_ready | input | 1 | Slave completes the current access |

## Verification
The request is accepted at edge E0. With a slave that adds w wait cycles to each access, the read occupies cycles 1 to w+1 after E0, the write follows it, and `done` is due in cycle 3+2w. A refused request shows `err` in cycle 1 with no bus strobe. The bench drives inputs and samples outputs on falling edges. It counts falling edges from acceptance, compares that count with 3+2w or 1, and checks one cycle later that the pulse has dropped. It then compares the bench's memory word, its read and write counters and the recorded write address against values worked out from the descriptor.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

  localparam int DESC_W    = 32;
  localparam int AOFF_W    = 16;
  localparam int FLEN_W    = 8;
  localparam int FPOS_W    = 8;

  typedef struct packed {
    logic [AOFF_W-1:0] aoff;
    logic [FLEN_W-1:0] flen;
    logic [FPOS_W-1:0] fpos;
  } fdesc_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } rmw_state_e;

endpackage

// File: rtl/regfield_decode.sv
module regfield_decode
  import regfield_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DESC_W-1:0] desc,
  output logic [ADDR_W-1:0] addr,
  output logic [FLEN_W-1:0] flen,
  output logic [FPOS_W-1:0] fpos,
  output logic              legal
);

  localparam int SUM_W = FLEN_W + 1;
  localparam logic [SUM_W-1:0] WORD_BITS = SUM_W'(DATA_W);

  fdesc_t            d;
  logic [SUM_W-1:0]  span_end;

  assign d        = fdesc_t'(desc);
  assign flen     = d.flen;
  assign fpos     = d.fpos;
  assign addr     = base + ADDR_W'(d.aoff);
  assign span_end = {1'b0, d.flen} + {1'b0, d.fpos};

  always_comb begin
    legal = 1'b1;
    if (d.flen == '0)                    legal = 1'b0;
    if ({1'b0, d.flen} > WORD_BITS)      legal = 1'b0;
    if (span_end > WORD_BITS)            legal = 1'b0;
  end

endmodule

// File: rtl/regfield_merge.sv
module regfield_merge
  import regfield_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] value,
  input  logic [FLEN_W-1:0] flen,
  input  logic [FPOS_W-1:0] fpos,
  output logic [DATA_W-1:0] new_word
);

  localparam int SUM_W = FLEN_W + 1;

  logic [SUM_W-1:0]  lo_bound;
  logic [SUM_W-1:0]  hi_bound;
  logic [DATA_W-1:0] kept_val;
  logic [DATA_W-1:0] placed;

  assign lo_bound = {1'b0, fpos};
  assign hi_bound = {1'b0, fpos} + {1'b0, flen};
  assign placed   = kept_val << fpos;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic in_len;
    logic in_field;
    assign in_len      = SUM_W'(i) < {1'b0, flen};
    assign in_field    = (SUM_W'(i) >= lo_bound) && (SUM_W'(i) < hi_bound);
    assign kept_val[i] = value[i] & in_len;
    assign new_word[i] = in_field ? placed[i] : old_word[i];
  end

endmodule

// File: rtl/regfield_seq.sv
module regfield_seq
  import regfield_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic legal,
  input  logic bus_ready,
  output logic req_ready,
  output logic take_req,
  output logic take_word,
  output logic rd_en,
  output logic wr_en,
  output logic done,
  output logic err,
  output logic busy
);

  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = legal ? ST_READ : ST_ERR;
      ST_READ:  if (bus_ready) state_d = ST_WRITE;
      ST_WRITE: if (bus_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_ERR:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign take_req  = req_ready && req_valid;
  assign rd_en     = (state_q == ST_READ);
  assign wr_en     = (state_q == ST_WRITE);
  assign take_word = rd_en && bus_ready;
  assign done      = (state_q == ST_DONE);
  assign err       = (state_q == ST_ERR);
  assign busy      = !req_ready;

endmodule

// File: rtl/regfield_rmw.sv
module regfield_rmw
  import regfield_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [DATA_W-1:0] req_value,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);

  logic [ADDR_W-1:0] dec_addr;
  logic [FLEN_W-1:0] dec_flen;
  logic [FPOS_W-1:0] dec_fpos;
  logic              dec_legal;
  logic              take_req;
  logic              take_word;
  logic [ADDR_W-1:0] addr_q;
  logic [FLEN_W-1:0] flen_q;
  logic [FPOS_W-1:0] fpos_q;
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] merged;

  regfield_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .base  (req_base),
    .desc  (req_desc),
    .addr  (dec_addr),
    .flen  (dec_flen),
    .fpos  (dec_fpos),
    .legal (dec_legal)
  );

  regfield_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .legal     (dec_legal),
    .bus_ready (bus_ready),
    .req_ready (req_ready),
    .take_req  (take_req),
    .take_word (take_word),
    .rd_en     (bus_rd),
    .wr_en     (bus_wr),
    .done      (done),
    .err       (err),
    .busy      (busy)
  );

  regfield_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (bus_rdata),
    .value    (value_q),
    .flen     (flen_q),
    .fpos     (fpos_q),
    .new_word (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      flen_q  <= '0;
      fpos_q  <= '0;
      value_q <= '0;
      wdata_q <= '0;
    end else begin
      if (take_req) begin
        addr_q  <= dec_addr;
        flen_q  <= dec_flen;
        fpos_q  <= dec_fpos;
        value_q <= req_value;
      end
      if (take_word) wdata_q <= merged;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/regfield_rmw_chk.sv
module regfield_rmw_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready
);

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)) else $error("strobe overlap"); // R4

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd && bus_ready)) else $error("write without read"); // R4

  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> (bus_addr == $past(bus_addr))) else $error("address moved"); // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr))) else $error("read dropped"); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)))
    else $error("write dropped"); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_rd && !bus_wr && !busy)) else $error("idle traffic"); // R6

  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_wr && bus_ready)) else $error("early done"); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done too long"); // R7

  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req_valid && req_ready) && !bus_rd && !bus_wr && !done))
    else $error("bad err"); // R8

endmodule

bind regfield_rmw regfield_rmw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready)
);

// File: tb/test_regfield_rmw.sv
module test_regfield_rmw;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [31:0] req_desc = '0;
  logic [31:0] req_value = '0;
  logic        busy, done, err;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  logic [31:0] mem [16];
  int          wait_n = 0;
  int          wcnt;
  int          n_rd, n_wr;
  logic [31:0] last_waddr;

  always #5 clk = ~clk;

  regfield_rmw i_regfield_rmw (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_desc(req_desc), .req_value(req_value),
    .busy(busy), .done(done), .err(err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  assign bus_ready = (bus_rd || bus_wr) && (wcnt >= wait_n);
  assign bus_rdata = mem[bus_addr[5:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h9E37_79B9 * (i + 1);
      wcnt <= 0; n_rd <= 0; n_wr <= 0; last_waddr <= '0;
    end else begin
      if ((bus_rd || bus_wr) && !bus_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (bus_rd && bus_ready) n_rd <= n_rd + 1;
      if (bus_wr && bus_ready) begin
        n_wr <= n_wr + 1;
        mem[bus_addr[5:2]] <= bus_wdata;
        last_waddr <= bus_addr;
      end
    end
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk = n_chk + 1; n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<100000", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] old, input logic [31:0] v,
                                        input int w, input int p);
    logic [31:0] r = old;
    for (int b = 0; b < w; b++) r[p + b] = v[b];
    return r;
  endfunction

  // One request; legal descriptors checked for data, address, counts, latency
  task automatic run_req(input logic [31:0] base, input logic [15:0] aoff,
                         input int w, input int p, input logic [31:0] val,
                         input int ws, input string tag);
    logic [31:0] addr = base + {16'h0, aoff};
    int          idx  = int'(addr[5:2]);
    logic [31:0] old  = mem[idx];
    int          r0   = n_rd;
    int          w0   = n_wr;
    bit          legal = (w >= 1) && (w <= 32) && (p + w <= 32);
    int          lat  = 1;
    logic [31:0] expw;
    wait_n = ws;
    @(negedge clk);
    req_base = base; req_desc = {aoff, 8'(w), 8'(p)}; req_value = val; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && busy, {tag, " R6 busy after accept"}, {30'd0, req_ready, busy}, 32'h1);
    while (!done && !err && lat < 200) begin
      @(negedge clk); lat++;
    end
    if (legal) begin
      chk(done && !err, {tag, " R7 done raised"}, {30'd0, done, err}, 32'h2);
      chk(lat == 3 + 2 * ws, {tag, " R5 R7 latency"}, lat, 3 + 2 * ws);
      expw = model(old, val, w, p);
      chk(mem[idx] == expw, {tag, " R2 R3 merged word"}, mem[idx], expw);
      chk(last_waddr == addr, {tag, " R1 write address"}, last_waddr, addr);
      chk((n_rd - r0 == 1) && (n_wr - w0 == 1), {tag, " R4 one read one write"},
          {n_rd - r0}[15:0] << 16 | (n_wr - w0), 32'h0001_0001);
    end else begin
      chk(err && !done && lat == 1, {tag, " R8 err in cycle 1"}, lat, 1);
      chk((n_rd == r0) && (n_wr == w0) && mem[idx] == old, {tag, " R8 no bus access"},
          mem[idx], old);
    end
    @(negedge clk);
    chk(!done && !err && req_ready, {tag, " R7 R8 pulse one cycle"},
        {29'd0, done, err, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    chk(req_ready && !bus_rd && !bus_wr && !done && !err && !busy, "R10 reset state",
        {26'd0, req_ready, bus_rd, bus_wr, done, err, busy}, 32'h20);
  endtask

  task automatic t_mid_field;   // value wider than field: truncation
    run_req(32'h4000_0000, 16'h0008, 4, 8, 32'hFFFF_FFF5, 0, "mid");
  endtask

  task automatic t_full_word;   // R9
    run_req(32'h4000_0000, 16'h0010, 32, 0, 32'hCAFE_F00D, 0, "R9 full");
    chk(mem[4] == 32'hCAFE_F00D, "R9 whole word", mem[4], 32'hCAFE_F00D);
  endtask

  task automatic t_edges;       // top bit, bottom bit, address wrap to idx 1
    run_req(32'h4000_0000, 16'h003C, 1, 31, 32'h0000_0000, 0, "R3 top bit");
    run_req(32'h4000_0000, 16'h0044, 1, 0, 32'h0000_0002, 0, "R2 bottom bit");
    run_req(32'h4000_0020, 16'h0004, 7, 25, 32'h0000_0055, 0, "R3 high field");
  endtask

  task automatic t_wait;        // R5 wait states
    run_req(32'h4000_0000, 16'h0024, 12, 4, 32'h0000_0ABC, 3, "R5 wait3");
    run_req(32'h4000_0000, 16'h0024, 16, 16, 32'h0001_1234, 1, "R5 wait1");
  endtask

  task automatic t_illegal;     // R8
    run_req(32'h4000_0000, 16'h000C, 0, 0, 32'hFFFF_FFFF, 0, "R8 width0");
    run_req(32'h4000_0000, 16'h000C, 33, 0, 32'hFFFF_FFFF, 0, "R8 width33");
    run_req(32'h4000_0000, 16'h000C, 3, 30, 32'hFFFF_FFFF, 0, "R8 overrun");
    run_req(32'h4000_0000, 16'h000C, 2, 30, 32'h0000_0001, 0, "R8 exact fit ok");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mid_field();
    t_full_word();
    t_edges();
    t_wait();
    t_illegal();
    repeat (2) @(negedge clk);
    report();
  end

endmodule